// File: doc/BRIEF.md
# Defect-Avoiding Path Configuration Loader

This block brings up a reconfigurable fabric one point-to-point connection at a time. It reads records from a read-only memory. Each record describes one connection between a single source and a single sink, so a net with several sinks takes one record per sink. A record holds a header, some optional metadata words that are skipped, and a list of candidate path configurations. The default path comes first, then up to seven alternatives. The loader writes a candidate into the fabric through a configuration write port. It then toggles the connection's source and watches its sink. If the sink follows, the candidate is kept. If not, the loader erases that candidate and tries the next one.

Every alternative is built so that it never collides with another net's default path. For this reason a connection that has been kept is never tested or rewritten again. Records are handled in memory order, which is the logical order of the nets and not their physical position. If a connection runs out of candidates, the whole load stops with an abort indication. When the loader reaches an end marker, it signals completion. For each connection it keeps, it emits a one-cycle status pulse with the net's index and the index of the chosen candidate.

Top module: `cfg_path_loader`

## Requirements
- R1: Records are handled in memory order. Each kept connection produces exactly one status pulse, carrying the running net index (starting at 0 for the first record after start) and the chosen candidate index (0 = default path, k = k-th alternative).
- R2: For each record the default path is written and tested first. Alternatives are written in list order, each one only after the previous candidate failed. Candidates after the passing one are never written.
- R3: A candidate passes only if the sink reads 1 after the source rises and reads 0 after the source falls. A sink stuck at 0 or stuck at 1 fails.
- R4: Header word layout: bits [3:0] hold the configuration words per path, bits [6:4] the alternative count (0 to 7), and bits [10:7] the metadata word count. A header whose word count is 0 marks the end of the list. The loader then raises done with no further writes.
- R5: If the last candidate of a record fails, the loader raises abort and returns to idle. It makes no further configuration writes, emits no status pulse for that record, and never raises done.
- R6: Before moving to the next candidate, the loader writes every word of the failed candidate again, in the same order, with the clear flag set. Writes for installing a candidate have the clear flag low.
- R7: In each test phase, the sink is sampled settle_i cycles after the source edge that started the phase. A sink that lags the source by up to settle_i cycles passes; a sink that lags by more fails.
- R8: Metadata words sit between the header and the first candidate. They are never written to the fabric.
- R9: The status pulse lasts exactly one cycle.
- R10: start_i is ignored while busy. Done and abort hold their values until the next accepted start.
- R11: Configuration writes occur only while busy, and only while the source is held low. The source stays low whenever the loader is idle.
- R12: After reset the loader is idle. Busy, done, abort, status, write enable and source are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load from the base address (accepted only while idle) |
| settle_i | input | CNT_W | Cycles between a source edge and the sink sample (typically 4) |
| rom_addr_o | output | ADDR_W | Record memory address; the data is expected on the next cycle |
| rom_rdata_i | input | DATA_W | Record memory read data |
| cfg_we_o | output | 1 | Configuration word write strobe |
| cfg_clr_o | output | 1 | Marks the write as an erase of that word |
| cfg_data_o | output | DATA_W | Configuration word |
| src_o | output | 1 | Test drive to the source of the connection under test |
| sink_i | input | 1 | Sampled sink of the connection under test |
| stat_vld_o | output | 1 | One-cycle pulse when a connection is kept |
| stat_net_o | output | NET_W | Net index of the kept connection |
| stat_cand_o | output | 3 | Chosen candidate index (0 = default) |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | All records kept; held until the next start |
| abort_o | output | 1 | A record exhausted its candidates; held until the next start |

## Verification
Two events can land in the same cycle: a start request and the status pulse of a kept connection. If start were wrongly accepted there, the net numbering would be thrown off or a second load would begin. The bench holds start high from launch through the cycle that closes the first status pulse. It then checks that the run produces exactly the expected pulses with consecutive net indices, that it ends in done, and that no new load starts afterwards. Separately, the exact order of the erase writes and the install writes is compared word by word against a sequence the bench builds itself.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HREQ,
    ST_HCAP,
    ST_WREQ,
    ST_WDO,
    ST_TEST
  } st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_RISE,
    PH_FALL
  } ph_e;

  typedef struct packed {
    logic [3:0] meta;
    logic [2:0] alts;
    logic [3:0] wpp;
  } hdr_t;

  localparam int HDR_W = 11;

endpackage

// File: rtl/cpl_settle_cnt.sv
module cpl_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cpl_path_test.sv
module cpl_path_test
  import cpl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             sink_i,
  output logic             src_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o
);

  ph_e  ph_q;
  logic err_q;
  logic zero;
  logic load;

  // every phase boundary reloads the settle window
  assign load = ((ph_q == PH_IDLE) && go_i) || ((ph_q != PH_IDLE) && zero);

  cpl_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (settle_i),
    .zero_o (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      err_q  <= 1'b0;
      src_o  <= 1'b0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_PRE;
          src_o <= 1'b0;
          err_q <= 1'b0;
        end
        PH_PRE: if (zero) begin
          ph_q  <= PH_RISE;
          src_o <= 1'b1;
        end
        PH_RISE: if (zero) begin
          err_q <= err_q | ~sink_i;
          ph_q  <= PH_FALL;
          src_o <= 1'b0;
        end
        PH_FALL: if (zero) begin
          ph_q   <= PH_IDLE;
          done_o <= 1'b1;
          pass_o <= ~(err_q | sink_i);
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);

endmodule

// File: rtl/cpl_hdr_dec.sv
module cpl_hdr_dec
  import cpl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [HDR_W-1:0]  word_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [3:0]        wpp_o,
  output logic [2:0]        alts_o,
  output logic              end_o,
  output logic [ADDR_W-1:0] cand0_o,
  output logic [ADDR_W-1:0] next_o
);

  localparam int PADW = ADDR_W - 8;

  hdr_t       hdr;
  logic [7:0] span;

  assign hdr    = hdr_t'(word_i);
  assign wpp_o  = hdr.wpp;
  assign alts_o = hdr.alts;
  assign end_o  = (hdr.wpp == 4'd0);

  // all candidates of a record share one length
  assign span    = ({5'd0, hdr.alts} + 8'd1) * {4'd0, hdr.wpp};
  assign cand0_o = base_i + {{PADW{1'b0}}, 4'd0, hdr.meta} + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign next_o  = cand0_o + {{PADW{1'b0}}, span};

endmodule

// File: rtl/cfg_path_loader.sv
module cfg_path_loader
  import cpl_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter int                NET_W     = 10,
  parameter int                CNT_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  settle_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              cfg_we_o,
  output logic              cfg_clr_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              src_o,
  input  logic              sink_i,
  output logic              stat_vld_o,
  output logic [NET_W-1:0]  stat_net_o,
  output logic [2:0]        stat_cand_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o
);

  localparam int WPADW = ADDR_W - 4;

  st_e               st_q;
  logic [ADDR_W-1:0] rec_base_q, cand_base_q, next_base_q;
  logic [3:0]        wpp_q, word_q;
  logic [2:0]        alts_q, cand_q;
  logic              clr_q;
  logic [NET_W-1:0]  net_q;
  logic              done_q, abort_q;

  logic [3:0]        d_wpp;
  logic [2:0]        d_alts;
  logic              d_end;
  logic [ADDR_W-1:0] d_cand0, d_next;

  logic              last_word;
  logic              t_go, t_busy, t_done, t_pass;

  cpl_hdr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .word_i  (rom_rdata_i[HDR_W-1:0]),
    .base_i  (rec_base_q),
    .wpp_o   (d_wpp),
    .alts_o  (d_alts),
    .end_o   (d_end),
    .cand0_o (d_cand0),
    .next_o  (d_next)
  );

  assign last_word = (word_q == wpp_q - 4'd1);
  assign t_go      = (st_q == ST_WDO) && last_word && !clr_q;

  cpl_path_test #(.CNT_W(CNT_W)) u_test (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (t_go),
    .settle_i (settle_i),
    .sink_i   (sink_i),
    .src_o    (src_o),
    .busy_o   (t_busy),
    .done_o   (t_done),
    .pass_o   (t_pass)
  );

  assign rom_addr_o = (st_q == ST_HREQ) ? rec_base_q
                                        : cand_base_q + {{WPADW{1'b0}}, word_q};
  assign cfg_we_o   = (st_q == ST_WDO);
  assign cfg_clr_o  = (st_q == ST_WDO) && clr_q;
  assign cfg_data_o = rom_rdata_i;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign abort_o    = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rec_base_q  <= BASE_ADDR;
      cand_base_q <= '0;
      next_base_q <= '0;
      wpp_q       <= '0;
      alts_q      <= '0;
      word_q      <= '0;
      cand_q      <= '0;
      clr_q       <= 1'b0;
      net_q       <= '0;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
      stat_vld_o  <= 1'b0;
      stat_net_o  <= '0;
      stat_cand_o <= '0;
    end else begin
      stat_vld_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          done_q     <= 1'b0;
          abort_q    <= 1'b0;
          net_q      <= '0;
          rec_base_q <= BASE_ADDR;
          st_q       <= ST_HREQ;
        end
        ST_HREQ: st_q <= ST_HCAP;
        ST_HCAP: begin
          if (d_end) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            wpp_q       <= d_wpp;
            alts_q      <= d_alts;
            cand_base_q <= d_cand0;
            next_base_q <= d_next;
            cand_q      <= '0;
            word_q      <= '0;
            clr_q       <= 1'b0;
            st_q        <= ST_WREQ;
          end
        end
        ST_WREQ: st_q <= ST_WDO;
        ST_WDO: begin
          if (!last_word) begin
            word_q <= word_q + 4'd1;
            st_q   <= ST_WREQ;
          end else if (clr_q) begin
            // erase finished: step to the next candidate
            word_q      <= '0;
            clr_q       <= 1'b0;
            cand_q      <= cand_q + 3'd1;
            cand_base_q <= cand_base_q + {{WPADW{1'b0}}, wpp_q};
            st_q        <= ST_WREQ;
          end else begin
            st_q <= ST_TEST;
          end
        end
        ST_TEST: if (t_done) begin
          if (t_pass) begin
            stat_vld_o  <= 1'b1;
            stat_net_o  <= net_q;
            stat_cand_o <= cand_q;
            net_q       <= net_q + 1'b1;
            rec_base_q  <= next_base_q;
            st_q        <= ST_HREQ;
          end else if (cand_q == alts_q) begin
            abort_q <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            clr_q  <= 1'b1;
            word_q <= '0;
            st_q   <= ST_WREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_busy;
  assign unused_busy = t_busy;

endmodule

// File: rtl/cpl_loader_chk.sv
module cpl_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cfg_we_o,
  input logic src_o,
  input logic stat_vld_o,
  input logic busy_o,
  input logic done_o,
  input logic abort_o
);

  // R5
  a_r5_done_abort_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && abort_o));

  // R5
  a_r5_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !busy_o && !cfg_we_o);

  // R11
  a_r11_we_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> busy_o);

  // R11
  a_r11_src_low_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> !src_o);

  // R11
  a_r11_idle_src_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !src_o);

  // R9
  a_r9_stat_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_o |=> !stat_vld_o);

  // R10
  a_r10_launch_by_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R10
  a_r10_abort_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !start_i |=> abort_o);

  // R10
  a_r10_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

endmodule

bind cfg_path_loader cpl_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cfg_we_o   (cfg_we_o),
  .src_o      (src_o),
  .stat_vld_o (stat_vld_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .abort_o    (abort_o)
);

// File: tb/cfg_path_loader_tb.sv
module cfg_path_loader_tb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NET_W  = 10;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  settle = 8'd4;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_rdata;
  logic              cfg_we, cfg_clr;
  logic [DATA_W-1:0] cfg_data;
  logic              src, sink;
  logic              stat_vld;
  logic [NET_W-1:0]  stat_net;
  logic [2:0]        stat_cand;
  logic              busy, done, abort_s;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  cfg_path_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NET_W(NET_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_i(settle),
    .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .cfg_we_o(cfg_we), .cfg_clr_o(cfg_clr), .cfg_data_o(cfg_data),
    .src_o(src), .sink_i(sink),
    .stat_vld_o(stat_vld), .stat_net_o(stat_net), .stat_cand_o(stat_cand),
    .busy_o(busy), .done_o(done), .abort_o(abort_s)
  );

  // record memory
  logic [31:0] rom [0:255];
  always @(posedge clk) rom_rdata <= rom[rom_addr[7:0]];

  // fabric model: mode 0 good, 1 stuck low, 2 stuck high
  logic [1:0] mode_tab [0:255];
  logic [7:0] inst_key;
  logic       inst_vld = 1'b0;
  logic [7:0] sh = '0;
  int         dly = 1;

  always @(posedge clk) begin
    sh <= {sh[6:0], src};
    if (cfg_we) begin
      if (cfg_clr) inst_vld <= 1'b0;
      else if (cfg_data[3:0] == 4'd0) begin
        inst_vld <= 1'b1;
        inst_key <= {cfg_data[12:8], cfg_data[6:4]};
      end
    end
  end

  assign sink = !inst_vld ? 1'b0 :
                (mode_tab[inst_key] == 2'd1) ? 1'b0 :
                (mode_tab[inst_key] == 2'd2) ? 1'b1 : sh[dly-1];

  // logs
  int          wr_tot = 0;
  logic [31:0] wr_data [0:1023];
  logic        wr_clr  [0:1023];
  int          st_tot = 0;
  int          st_net  [0:255];
  int          st_cand [0:255];

  always @(posedge clk) begin
    if (cfg_we) begin
      wr_data[wr_tot[9:0]] <= cfg_data;
      wr_clr[wr_tot[9:0]]  <= cfg_clr;
      wr_tot <= wr_tot + 1;
    end
    if (stat_vld) begin
      st_net[st_tot[7:0]]  <= int'(stat_net);
      st_cand[st_tot[7:0]] <= int'(stat_cand);
      st_tot <= st_tot + 1;
    end
  end

  int ptr;
  int wr_base, st_base;

  function automatic logic [31:0] cw(int net, int cand, int w);
    return {16'hA5A5, net[7:0], 1'b0, cand[2:0], w[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rom_clear();
    for (int i = 0; i < 256; i++) begin rom[i] = '0; mode_tab[i] = 2'd0; end
    ptr = 0;
  endtask

  task automatic add_rec(input int net, input int wpp, input int alts, input int meta);
    rom[ptr] = {21'd0, meta[3:0], alts[2:0], wpp[3:0]};
    ptr++;
    for (int m = 0; m < meta; m++) begin rom[ptr] = 32'hDEAD_0000 + m; ptr++; end
    for (int c = 0; c <= alts; c++)
      for (int w = 0; w < wpp; w++) begin rom[ptr] = cw(net, c, w); ptr++; end
  endtask

  task automatic set_mode(input int net, input int cand, input int m);
    mode_tab[{net[4:0], cand[2:0]}] = m[1:0];
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (busy && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic run_load();
    @(negedge clk);
    wr_base = wr_tot;
    st_base = st_tot;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  // expected write k relative to run start
  task automatic chk_wr(input string req, input int k, input logic [31:0] d, input bit c);
    chk(wr_data[wr_base + k] == d, req, $sformatf("write %0d data", k),
        int'(wr_data[wr_base + k][15:0]), int'(d[15:0]));
    chk(wr_clr[wr_base + k] == c, req, $sformatf("write %0d clear flag", k),
        int'(wr_clr[wr_base + k]), int'(c));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !abort_s, "R12", "idle status", {busy, done, abort_s}, 0);
    chk(!cfg_we && !src && !stat_vld, "R12", "idle outputs", {cfg_we, src, stat_vld}, 0);
  endtask

  task automatic t_all_good();
    int meta_hits;
    rom_clear();
    add_rec(0, 2, 1, 0);
    add_rec(1, 1, 0, 2);
    add_rec(2, 3, 2, 1);
    run_load();
    chk(done && !abort_s, "R4", "done after end marker", {done, abort_s}, 2);
    chk(st_tot - st_base == 3, "R1", "status pulses", st_tot - st_base, 3);
    for (int i = 0; i < 3; i++) begin
      chk(st_net[st_base + i] == i, "R1", "net index", st_net[st_base + i], i);
      chk(st_cand[st_base + i] == 0, "R2", "default chosen", st_cand[st_base + i], 0);
    end
    chk(wr_tot - wr_base == 6, "R2", "only defaults written", wr_tot - wr_base, 6);
    chk_wr("R1", 0, cw(0, 0, 0), 1'b0);
    chk_wr("R1", 2, cw(1, 0, 0), 1'b0);
    chk_wr("R1", 5, cw(2, 0, 2), 1'b0);
    meta_hits = 0;
    for (int i = wr_base; i < wr_tot; i++) if (wr_data[i][31:16] == 16'hDEAD) meta_hits++;
    chk(meta_hits == 0, "R8", "metadata writes", meta_hits, 0);
  endtask

  task automatic t_fallback();
    rom_clear();
    add_rec(0, 2, 2, 1);
    add_rec(1, 1, 0, 0);
    set_mode(0, 0, 1);
    run_load();
    chk(done, "R3", "done after stuck-low fallback", done, 1);
    chk(st_cand[st_base] == 1, "R3", "stuck-low default rejected", st_cand[st_base], 1);
    chk(st_cand[st_base + 1] == 0, "R2", "next net default", st_cand[st_base + 1], 0);
    chk(wr_tot - wr_base == 7, "R6", "write count", wr_tot - wr_base, 7);
    chk_wr("R6", 0, cw(0, 0, 0), 1'b0);
    chk_wr("R6", 1, cw(0, 0, 1), 1'b0);
    chk_wr("R6", 2, cw(0, 0, 0), 1'b1);
    chk_wr("R6", 3, cw(0, 0, 1), 1'b1);
    chk_wr("R2", 4, cw(0, 1, 0), 1'b0);
    chk_wr("R2", 5, cw(0, 1, 1), 1'b0);
    chk_wr("R1", 6, cw(1, 0, 0), 1'b0);
  endtask

  task automatic t_both_edges();
    rom_clear();
    add_rec(0, 1, 3, 0);
    set_mode(0, 0, 2);
    set_mode(0, 1, 1);
    run_load();
    chk(st_cand[st_base] == 2, "R3", "stuck-high and stuck-low rejected", st_cand[st_base], 2);
    chk(wr_tot - wr_base == 5, "R2", "later alternative untouched", wr_tot - wr_base, 5);
    chk_wr("R2", 4, cw(0, 2, 0), 1'b0);
  endtask

  task automatic t_abort();
    int late;
    rom_clear();
    add_rec(0, 1, 0, 0);
    add_rec(1, 2, 1, 0);
    add_rec(2, 1, 0, 0);
    set_mode(1, 0, 1);
    set_mode(1, 1, 1);
    run_load();
    chk(abort_s && !done, "R5", "abort without done", {abort_s, done}, 2);
    chk(st_tot - st_base == 1, "R5", "status pulses before abort", st_tot - st_base, 1);
    late = 0;
    for (int i = wr_base; i < wr_tot; i++) if (wr_data[i][15:8] == 8'd2) late++;
    chk(late == 0, "R5", "writes after failed record", late, 0);
    chk(wr_tot - wr_base == 1 + 2 + 2 + 2, "R5", "write count", wr_tot - wr_base, 7);
    repeat (20) @(negedge clk);
    chk(abort_s && !busy, "R10", "abort held while idle", {abort_s, busy}, 2);
  endtask

  task automatic t_settle();
    rom_clear();
    add_rec(0, 1, 0, 0);
    dly = 4;
    settle = 8'd3;
    run_load();
    chk(abort_s, "R7", "lag beyond settle fails", abort_s, 1);
    settle = 8'd4;
    run_load();
    chk(done && !abort_s, "R7", "lag equal to settle passes", {done, abort_s}, 2);
    dly = 1;
  endtask

  task automatic t_max_alts();
    rom_clear();
    add_rec(0, 1, 7, 0);
    for (int c = 0; c < 7; c++) set_mode(0, c, (c % 2) + 1);
    run_load();
    chk(done, "R2", "done with last alternative", done, 1);
    chk(st_cand[st_base] == 7, "R2", "seventh alternative chosen", st_cand[st_base], 7);
    chk(wr_tot - wr_base == 15, "R6", "seven erases plus eight installs", wr_tot - wr_base, 15);
  endtask

  task automatic t_empty();
    rom_clear();
    run_load();
    chk(done && !abort_s, "R4", "empty list done", {done, abort_s}, 2);
    chk(wr_tot == wr_base && st_tot == st_base, "R4", "no activity", wr_tot - wr_base, 0);
  endtask

  task automatic t_start_busy();
    int g;
    rom_clear();
    add_rec(0, 1, 0, 0);
    add_rec(1, 2, 0, 0);
    @(negedge clk);
    wr_base = wr_tot;
    st_base = st_tot;
    start = 1'b1;
    g = 0;
    while (!stat_vld && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(st_tot - st_base == 2, "R10", "pulses with start held", st_tot - st_base, 2);
    chk(st_net[st_base + 1] == 1, "R10", "net index not restarted", st_net[st_base + 1], 1);
    repeat (20) @(negedge clk);
    chk(done && !busy, "R10", "no relaunch after done", {done, busy}, 2);
    chk(st_tot - st_base == 2, "R9", "one pulse per net", st_tot - st_base, 2);
  endtask

  initial begin
    rom_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_all_good();
    t_fallback();
    t_both_edges();
    t_abort();
    t_settle();
    t_max_alts();
    t_empty();
    t_start_busy();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule